// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a CPU-facing parallel I/O device with three 8-bit ports and a control word register. A processor reaches it through an 8-bit data bus with active-low chip select, read and write strobes and a 2-bit register address. The control word sets the direction of port A, port B and each half of port C. Port C is handled as two 4-bit halves, each with its own latch and direction.

Each output port holds the last value written to its latch. An input port passes its live pins back to the processor on a read. A control write with the top bit clear does not change the mode. Instead, it sets or clears one port C latch bit. A mode-set write clears every output latch.

All bus strobes are sampled on the rising clock edge. Read data and its output enable are registered, so they appear one cycle after the read is sampled. The bus is modelled as separate input, output and output-enable signals, not as a tri-state pin.

Top module: `ppi_core`

## Requirements
- R1: No register changes and `dout_oe` stays low in any cycle where `cs_n` is high, whatever `rd_n`, `wr_n` and `addr` do.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control word, for both reads and writes.
- R3: While `rst` is high, the control word becomes 9Bh, every output latch becomes 0 and all port output enables go low.
- R4: In a mode-set word, bit 4 sets port A direction, bit 3 sets the upper port C half, bit 1 sets port B and bit 0 sets the lower port C half. A 1 means input (enable low) and a 0 means output (enable high).
- R5: A control write with bit 7 = 1 stores the word and clears all port latches (A, B, both C halves) on the same edge.
- R6: A control write with bit 7 = 0 leaves the control word unchanged. It writes bit 0 of the data into the port C latch bit numbered by data bits 3:1, and leaves the other bits unchanged.
- R7: A read of a port returns the latch value for each half or port set as output, and the live pin value for each one set as input. Port C mixes the two per nibble.
- R8: `dout_oe` is high in the cycle after a cycle with `cs_n` and `rd_n` both low, and low otherwise. `dout` then carries the selected value.
- R9: A port write takes effect on the port's output latch one clock after the write is sampled.
- R10: A read at address 3 returns the stored control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Registered read data |
| dout_oe | output | 1 | Processor data bus drive enable |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C latch (both halves) |
| pc_oe | output | 2 | Port C output enables, bit 1 upper half, bit 0 lower half |

## Verification
The bench builds the block with its default parameters: 8-bit ports and a reset word of 9Bh. With these defaults the all-input reset state and the 3-bit port C bit index are in range. Every set/reset index from the lowest to the top bit of the upper half is reachable, so the half selection on bit 3 of the data gets exercised. A mixed word with one port C half as input and the other as output shows the per-nibble read selection and the clearing of latches on a mode change.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    SEL_PA = 2'd0,
    SEL_PB = 2'd1,
    SEL_PC = 2'd2,
    SEL_CW = 2'd3
  } sel_e;

  // control word bit positions
  localparam int CW_MODE_SET = 7;
  localparam int CW_A_IN     = 4;
  localparam int CW_CU_IN    = 3;
  localparam int CW_B_IN     = 1;
  localparam int CW_CL_IN    = 0;
endpackage

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
  import ppi_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  output logic       wr_pa,
  output logic       wr_pb,
  output logic       wr_pc,
  output logic       wr_cw,
  output logic       rd_en
);
  logic wr_en;
  assign wr_en = !cs_n && !wr_n;
  assign rd_en = !cs_n && !rd_n;

  always_comb begin
    wr_pa = 1'b0;
    wr_pb = 1'b0;
    wr_pc = 1'b0;
    wr_cw = 1'b0;
    if (wr_en) begin
      unique case (sel_e'(addr))
        SEL_PA: wr_pa = 1'b1;
        SEL_PB: wr_pb = 1'b1;
        SEL_PC: wr_pc = 1'b1;
        SEL_CW: wr_cw = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
#(
  parameter int          CW_W       = 8,
  parameter logic [7:0]  RESET_WORD = 8'h9B,
  parameter int          IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cw,
  input  logic [CW_W-1:0]  din,
  output logic [CW_W-1:0]  cw_q,
  output logic             mode_load,
  output logic             sr_we,
  output logic [IDX_W-1:0] sr_idx,
  output logic             sr_val
);
  assign mode_load = wr_cw && din[CW_MODE_SET];
  assign sr_we     = wr_cw && !din[CW_MODE_SET];
  assign sr_idx    = din[IDX_W:1];
  assign sr_val    = din[0];

  always_ff @(posedge clk) begin
    if (rst)            cw_q <= CW_W'(RESET_WORD);
    else if (mode_load) cw_q <= din;
  end

  assert_reset_word_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cw_q == CW_W'(RESET_WORD));

  assert_cw_kept_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!mode_load)) |-> $stable(cw_q));
endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [W-1:0]     d,
  input  logic             bit_we,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [W-1:0]     q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (we)    q <= d;
    else if (bit_we) q[bit_idx] <= bit_val;
  end

  assert_clear_on_mode_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(clr)) |-> q == '0);

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(we && !clr)) |-> q == $past(d));

  assert_single_bit_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(bit_we && !we && !clr)) |-> q[$past(bit_idx)] == $past(bit_val));
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
#(
  parameter int         PORT_W     = 8,
  parameter logic [7:0] RESET_WORD = 8'h9B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  output logic              dout_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic              pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [1:0]        pc_oe
);
  localparam int NIB_W   = PORT_W / 2;
  localparam int IDX_W   = $clog2(PORT_W);
  localparam int NIDX_W  = $clog2(NIB_W);

  logic wr_pa, wr_pb, wr_pc, wr_cw, rd_en;
  logic [PORT_W-1:0] cw_q;
  logic mode_load, sr_we, sr_val;
  logic [IDX_W-1:0] sr_idx;
  logic [1:0] c_in_dir;
  logic [PORT_W-1:0] rd_val;

  ppi_bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_pa(wr_pa), .wr_pb(wr_pb), .wr_pc(wr_pc), .wr_cw(wr_cw), .rd_en(rd_en)
  );

  ppi_ctrl_reg #(.CW_W(PORT_W), .RESET_WORD(RESET_WORD), .IDX_W(IDX_W)) u_cw (
    .clk(clk), .rst(rst), .wr_cw(wr_cw), .din(din), .cw_q(cw_q),
    .mode_load(mode_load), .sr_we(sr_we), .sr_idx(sr_idx), .sr_val(sr_val)
  );

  ppi_port_latch #(.W(PORT_W)) u_pa (
    .clk(clk), .rst(rst), .clr(mode_load), .we(wr_pa), .d(din),
    .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out)
  );

  ppi_port_latch #(.W(PORT_W)) u_pb (
    .clk(clk), .rst(rst), .clr(mode_load), .we(wr_pb), .d(din),
    .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out)
  );

  assign c_in_dir = {cw_q[CW_CU_IN], cw_q[CW_CL_IN]};

  for (genvar h = 0; h < 2; h++) begin : g_pc_half
    logic half_bit_we;
    assign half_bit_we = sr_we && (sr_idx[IDX_W-1] == h[0]);
    ppi_port_latch #(.W(NIB_W), .IDX_W(NIDX_W)) u_pc (
      .clk(clk), .rst(rst), .clr(mode_load), .we(wr_pc),
      .d(din[h*NIB_W +: NIB_W]),
      .bit_we(half_bit_we), .bit_idx(sr_idx[NIDX_W-1:0]), .bit_val(sr_val),
      .q(pc_out[h*NIB_W +: NIB_W])
    );
    assign pc_oe[h] = !c_in_dir[h];
  end

  assign pa_oe = !cw_q[CW_A_IN];
  assign pb_oe = !cw_q[CW_B_IN];

  always_comb begin
    unique case (sel_e'(addr))
      SEL_PA: rd_val = pa_oe ? pa_out : pa_in;
      SEL_PB: rd_val = pb_oe ? pb_out : pb_in;
      SEL_PC: begin
        rd_val[NIB_W-1:0]      = pc_oe[0] ? pc_out[NIB_W-1:0]      : pc_in[NIB_W-1:0];
        rd_val[PORT_W-1:NIB_W] = pc_oe[1] ? pc_out[PORT_W-1:NIB_W] : pc_in[PORT_W-1:NIB_W];
      end
      SEL_CW: rd_val = cw_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= rd_en ? rd_val : '0;
      dout_oe <= rd_en;
    end
  end

  assert_bus_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !dout_oe);

  assert_bus_drive_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cs_n && !rd_n)) |-> dout_oe);

  assert_no_write_unselected_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cs_n)) |-> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

  assert_dir_onreset_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pa_oe && !pb_oe && pc_oe == 2'b00));
endmodule

// File: tb/test_ppi_core.sv
module test_ppi_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, pa_out, pb_out, pc_out;
  logic dout_oe, pa_oe, pb_oe;
  logic [1:0] pc_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ppi_core i_ppi_core (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    d = dout; oe = dout_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk("R3 pa_oe", pa_oe, 0);
    chk("R3 pb_oe", pb_oe, 0);
    chk("R3 pc_oe", pc_oe, 0);
    chk("R3 latches", {pa_out, pb_out, pc_out}, 0);
    chk("R8 idle oe", dout_oe, 0);
    bus_read(2'd3, d, oe);
    chk("R10 reset word", d, 8'h9B);
    chk("R8 oe during read", oe, 1);
    @(negedge clk);
    chk("R8 oe after read", dout_oe, 0);
  endtask

  task automatic t_input_reads;
    logic [7:0] d; logic oe;
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h71;
    bus_read(2'd0, d, oe); chk("R7 R2 read A pins", d, 8'h5A);
    bus_read(2'd1, d, oe); chk("R7 R2 read B pins", d, 8'hC3);
    bus_read(2'd2, d, oe); chk("R7 R2 read C pins", d, 8'h71);
  endtask

  task automatic t_outputs;
    logic [7:0] d; logic oe;
    bus_write(2'd3, 8'h80);
    chk("R4 all out oe", {pa_oe, pb_oe, pc_oe}, 4'hF);
    bus_write(2'd0, 8'h3C);
    chk("R9 pa_out", pa_out, 8'h3C);
    bus_write(2'd1, 8'hE1);
    chk("R9 pb_out", pb_out, 8'hE1);
    bus_read(2'd0, d, oe); chk("R7 read A latch", d, 8'h3C);
    bus_read(2'd3, d, oe); chk("R10 read cw", d, 8'h80);
  endtask

  task automatic t_unselected;
    logic [7:0] d; logic oe;
    bus_write(2'd1, 8'h00, 1'b1);
    chk("R1 write ignored", pb_out, 8'hE1);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; addr = 2'd0;
    @(negedge clk);
    chk("R1 no drive", dout_oe, 0);
    rd_n = 1'b1;
    bus_write(2'd3, 8'h00, 1'b1);
    bus_read(2'd3, d, oe);
    chk("R1 cw unchanged", d, 8'h80);
  endtask

  task automatic t_mode_clear_mixed;
    logic [7:0] d; logic oe;
    bus_write(2'd2, 8'hA5);
    chk("R9 pc_out", pc_out, 8'hA5);
    bus_write(2'd3, 8'h88);
    chk("R5 cleared", {pa_out, pb_out, pc_out}, 24'h0);
    chk("R4 mixed C oe", pc_oe, 2'b01);
    chk("R4 A B out", {pa_oe, pb_oe}, 2'b11);
    bus_write(2'd2, 8'h96);
    pc_in = 8'h3C;
    bus_read(2'd2, d, oe);
    chk("R7 mixed C read", d, 8'h36);
  endtask

  task automatic t_bit_set_reset;
    logic [7:0] d; logic oe;
    bus_write(2'd3, 8'h01);
    chk("R6 set bit0", pc_out, 8'h97);
    bus_write(2'd3, 8'h0E);
    chk("R6 clear bit7", pc_out, 8'h17);
    bus_write(2'd3, 8'h09);
    chk("R6 set bit4", pc_out, 8'h17);
    bus_write(2'd3, 8'h0B);
    chk("R6 set bit5", pc_out, 8'h37);
    bus_read(2'd3, d, oe);
    chk("R6 cw kept", d, 8'h88);
    chk("R6 A untouched", pa_out, 8'h00);
  endtask

  task automatic t_rereset;
    logic [7:0] d; logic oe;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R3 rereset latches", {pa_out, pb_out, pc_out}, 24'h0);
    chk("R3 rereset dirs", {pa_oe, pb_oe, pc_oe}, 4'h0);
    bus_read(2'd3, d, oe);
    chk("R3 rereset word", d, 8'h9B);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_input_reads();
    t_outputs();
    t_unselected();
    t_mode_clear_mixed();
    t_bit_set_reset();
    t_rereset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule